// File: doc/BRIEF.md
# Banked Multi-Context Register File

This block stores the working registers of a processor that keeps a full register set for each of sixteen hardware contexts. Each context has eight 16-bit registers: two accumulators (A, B), three index or working registers (X, Y, Z), a stack register (S), a status register (C) and a program-counter base (P). The datapath reaches the running context through a 4-bit register nibble. A word access names a register by its even nibble. A byte access names the upper byte with the even nibble and the lower byte with the odd nibble.

The same storage also appears as a 256-byte memory window. Context n fills window bytes 16n through 16n+15, with the registers in the order A, B, X, Y, Z, S, C, P and the upper byte first. Software can use the window to prepare or inspect any context. A window write into the running context cannot touch that context's C or P register.

A context switch changes the running context. In the same clock it records the outgoing interrupt level in the upper nibble of the incoming context's C register. The fields of the running context's C register are also presented as decoded outputs.

Top module: `ctx_regfile`

## Requirements
- R1: A word access (dp_word=1) addresses register dp_sel[3:1] of the running context, and dp_sel[0] is ignored. The read returns the register's even byte in bits 15:8 and its odd byte in bits 7:0. A word write stores dp_wdata[15:8] into the even byte and dp_wdata[7:0] into the odd byte.
- R2: A byte access (dp_word=0) addresses byte dp_sel of the running context. A byte read returns that byte zero-extended to 16 bits. A byte write stores dp_wdata[7:0] into that byte only.
- R3: Window byte address a maps to context a[7:4] and register byte a[3:0], using the same byte numbering as R2. mem_rdata returns that byte combinationally for any context.
- R4: A window write to a context other than the running one updates the addressed byte on the next clock.
- R5: A window write to the running context updates bytes 0x0 to 0xB (A to S). Bytes 0xC to 0xF (C and P) are left unchanged.
- R6: After reset, every register byte of every context is zero and the running context is 0.
- R7: When a datapath write and a window write hit the same byte in the same clock, the datapath value is stored.
- R8: When sw_en is high, cur_ctx takes sw_ctx on the next clock. In the same clock, bits 15:12 of the new context's C register take sw_ipl, and its other C bits are kept.
- R9: The status outputs decode the running context's C register: prev_ipl is bits 15:12, flag_zero bit 7, flag_minus bit 6, flag_fault bit 5, flag_link bit 4, and page_map bits 3:0.
- R10: Datapath writes to C and P of the running context are accepted. The window protection of R5 does not apply to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_sel | input | 4 | Register nibble for the datapath access |
| dp_word | input | 1 | 1 = word access, 0 = byte access |
| dp_we | input | 1 | Datapath write enable |
| dp_wdata | input | 16 | Datapath write data |
| dp_rdata | output | 16 | Datapath read data from the running context |
| mem_addr | input | 8 | Window byte address |
| mem_we | input | 1 | Window write enable |
| mem_wdata | input | 8 | Window write data |
| mem_rdata | output | 8 | Window read data |
| sw_en | input | 1 | Context switch request |
| sw_ctx | input | 4 | Context to switch to |
| sw_ipl | input | 4 | Interrupt level recorded in the new context's C register |
| cur_ctx | output | 4 | Running context |
| prev_ipl | output | 4 | C register bits 15:12 |
| flag_zero | output | 1 | C register bit 7 |
| flag_minus | output | 1 | C register bit 6 |
| flag_fault | output | 1 | C register bit 5 |
| flag_link | output | 1 | C register bit 4 |
| page_map | output | 4 | C register bits 3:0 |

## Verification
The hardest condition to reach from the ports is the window protection. It depends on the window address and the running context agreeing, which only happens after a switch. The stimulus therefore loads every context through the window from context 0. It then switches through all sixteen contexts, reading each one back through the datapath nibbles and the status outputs. Finally, it writes all sixteen window bytes of the running context and reads them back, which separates the protected bytes from the writable ones. A same-cycle collision of datapath and window writes on one byte is driven on purpose to show that the datapath value is kept.

// File: rtl/ctx_regfile.sv
module ctx_regfile #(
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       dp_sel,
  input  logic             dp_word,
  input  logic             dp_we,
  input  logic [15:0]      dp_wdata,
  output logic [15:0]      dp_rdata,
  input  logic [CTX_W+3:0] mem_addr,
  input  logic             mem_we,
  input  logic [7:0]       mem_wdata,
  output logic [7:0]       mem_rdata,
  input  logic             sw_en,
  input  logic [CTX_W-1:0] sw_ctx,
  input  logic [3:0]       sw_ipl,
  output logic [CTX_W-1:0] cur_ctx,
  output logic [3:0]       prev_ipl,
  output logic             flag_zero,
  output logic             flag_minus,
  output logic             flag_fault,
  output logic             flag_link,
  output logic [3:0]       page_map
);
  localparam int NCTX  = 1 << CTX_W;
  localparam int NBYTE = NCTX * 16;
  localparam int AW    = CTX_W + 4;

  logic [7:0] bank [NBYTE];

  logic [AW-1:0] hi_idx, lo_idx, byte_idx, st_hi, st_lo;
  logic          mem_guard;

  assign hi_idx   = {cur_ctx, dp_sel[3:1], 1'b0};
  assign lo_idx   = {cur_ctx, dp_sel[3:1], 1'b1};
  assign byte_idx = {cur_ctx, dp_sel};
  assign st_hi    = {cur_ctx, 4'hC};
  assign st_lo    = {cur_ctx, 4'hD};
  assign mem_guard = (mem_addr[AW-1:4] == cur_ctx) && (mem_addr[3:2] == 2'b11);

  assign dp_rdata  = dp_word ? {bank[hi_idx], bank[lo_idx]} : {8'h00, bank[byte_idx]};
  assign mem_rdata = bank[mem_addr];

  assign prev_ipl   = bank[st_hi][7:4];
  assign flag_zero  = bank[st_lo][7];
  assign flag_minus = bank[st_lo][6];
  assign flag_fault = bank[st_lo][5];
  assign flag_link  = bank[st_lo][4];
  assign page_map   = bank[st_lo][3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) bank[i] <= 8'h00;
      cur_ctx <= '0;
    end else begin
      if (mem_we && !mem_guard) bank[mem_addr] <= mem_wdata;
      if (sw_en) begin
        bank[{sw_ctx, 4'hC}][7:4] <= sw_ipl;
        cur_ctx <= sw_ctx;
      end
      if (dp_we) begin
        if (dp_word) begin
          bank[hi_idx] <= dp_wdata[15:8];
          bank[lo_idx] <= dp_wdata[7:0];
        end else begin
          bank[byte_idx] <= dp_wdata[7:0];
        end
      end
    end
  end

  a_r4_foreign_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[AW-1:4] != cur_ctx && !dp_we && !sw_en)
    |=> bank[$past(mem_addr)] == $past(mem_wdata));

  a_r5_guarded_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr[AW-1:4] == cur_ctx && mem_addr[3:2] == 2'b11 && !dp_we && !sw_en)
    |=> bank[$past(mem_addr)] == $past(mem_rdata));

  a_r7_datapath_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_we && !dp_word && mem_we && !sw_en && mem_addr == {cur_ctx, dp_sel})
    |=> bank[$past(mem_addr)] == $past(dp_wdata[7:0]));

  a_r8_switch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !dp_we) |=> (cur_ctx == $past(sw_ctx)) && (prev_ipl == $past(sw_ipl)));

  a_r1_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_we && dp_word && !sw_en) |=> (cur_ctx == $past(cur_ctx)) && dp_word && (dp_sel[3:1] == $past(dp_sel[3:1]))
      |-> dp_rdata == $past(dp_wdata));
endmodule

// File: tb/ctx_regfile_tb.sv
`timescale 1ns/1ps
module ctx_regfile_tb;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  dp_sel = 0;
  logic        dp_word = 0, dp_we = 0;
  logic [15:0] dp_wdata = 0, dp_rdata;
  logic [7:0]  mem_addr = 0, mem_wdata = 0, mem_rdata;
  logic        mem_we = 0, sw_en = 0;
  logic [3:0]  sw_ctx = 0, sw_ipl = 0, cur_ctx, prev_ipl, page_map;
  logic        flag_zero, flag_minus, flag_fault, flag_link;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_m [256];
  logic [3:0] ctx_m = 0;

  ctx_regfile u_dut (.clk, .rst_n, .dp_sel, .dp_word, .dp_we, .dp_wdata, .dp_rdata,
    .mem_addr, .mem_we, .mem_wdata, .mem_rdata, .sw_en, .sw_ctx, .sw_ipl, .cur_ctx,
    .prev_ipl, .flag_zero, .flag_minus, .flag_fault, .flag_link, .page_map);

  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    dp_we = 0; mem_we = 0; sw_en = 0;
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    mem_addr = a; mem_wdata = d; mem_we = 1;
    if (a[7:4] != ctx_m || a[3:2] != 2'b11) exp_m[a] = d;
    step();
  endtask

  task automatic dwrite(input logic [3:0] s, input logic w, input logic [15:0] d);
    dp_sel = s; dp_word = w; dp_wdata = d; dp_we = 1;
    if (w) begin
      exp_m[{ctx_m, s[3:1], 1'b0}] = d[15:8];
      exp_m[{ctx_m, s[3:1], 1'b1}] = d[7:0];
    end else exp_m[{ctx_m, s}] = d[7:0];
    step();
  endtask

  task automatic switch_to(input logic [3:0] c, input logic [3:0] ipl);
    sw_ctx = c; sw_ipl = ipl; sw_en = 1;
    exp_m[{c, 4'hC}] = {ipl, exp_m[{c, 4'hC}][3:0]};
    ctx_m = c;
    step();
  endtask

  task automatic check_ctx_reads(input string tag);
    for (int s = 0; s < 16; s++) begin
      dp_sel = 4'(s); dp_word = 0; #1;
      chk({tag, " R2 byte read"}, dp_rdata, {8'h00, exp_m[{ctx_m, 4'(s)}]});
      dp_word = 1; #1;
      chk({tag, " R1 word read"}, dp_rdata,
          {exp_m[{ctx_m, 3'(s >> 1), 1'b0}], exp_m[{ctx_m, 3'(s >> 1), 1'b1}]});
    end
    chk({tag, " R9 prev_ipl"}, 16'(prev_ipl), 16'(exp_m[{ctx_m, 4'hC}][7:4]));
    chk({tag, " R9 flags"}, 16'({flag_zero, flag_minus, flag_fault, flag_link}),
        16'(exp_m[{ctx_m, 4'hD}][7:4]));
    chk({tag, " R9 page_map"}, 16'(page_map), 16'(exp_m[{ctx_m, 4'hD}][3:0]));
  endtask

  task automatic check_window(input string tag);
    for (int a = 0; a < 256; a++) begin
      mem_addr = 8'(a); #1;
      chk(tag, 16'(mem_rdata), 16'(exp_m[a]));
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++) exp_m[a] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R6 ctx after reset", 16'(cur_ctx), 16'h0);
    check_window("R6 zero after reset");

    // R4: fill every other context through the window while context 0 runs
    for (int a = 16; a < 256; a++) mwrite(8'(a), pat(a));
    // R5: writes into running context 0; bytes 0xC..0xF stay zero
    for (int a = 0; a < 16; a++) mwrite(8'(a), pat(a) | 8'h01);
    check_window("R3 R4 R5 window readback");
    chk("R5 guarded byte 0x0C", 16'(exp_m[8'h0C]), 16'h0);

    // R8 R9 R1 R2: visit every context
    for (int c = 1; c < 16; c++) begin
      switch_to(4'(c), 4'(c) ^ 4'h5);
      chk("R8 cur_ctx", 16'(cur_ctx), 16'(c));
      check_ctx_reads("sweep");
    end
    switch_to(4'h0, 4'hA);
    chk("R8 back to ctx 0", 16'(cur_ctx), 16'h0);
    check_ctx_reads("ctx0");

    // R5 in a non-zero running context
    switch_to(4'h9, 4'h3);
    for (int b = 0; b < 16; b++) mwrite({4'h9, 4'(b)}, ~pat(b));
    check_ctx_reads("R5 own-context writes");
    chk("R5 P byte kept", 16'(exp_m[8'h9E]), 16'(pat(8'h9E)));

    // R10: datapath writes C and P
    dwrite(4'hC, 1, 16'h7B5A);
    dwrite(4'hF, 1, 16'hC3E1);
    check_ctx_reads("R10 dp writes C/P");
    mem_addr = 8'h9E; #1;
    chk("R10 P seen in window", 16'(mem_rdata), 16'h00C3);

    // R2: byte write leaves the sibling byte alone
    dwrite(4'h3, 0, 16'hFF44);
    dp_sel = 4'h2; dp_word = 1; #1;
    chk("R2 odd byte write", dp_rdata, {exp_m[8'h92], 8'h44});

    // R7: same-byte collision, datapath wins
    dp_sel = 4'h4; dp_word = 0; dp_wdata = 16'h0066; dp_we = 1;
    mem_addr = 8'h94; mem_wdata = 8'h99; mem_we = 1;
    exp_m[8'h94] = 8'h66;
    step();
    mem_addr = 8'h94; #1;
    chk("R7 collision", 16'(mem_rdata), 16'h0066);

    // R1: odd nibble in word write hits the same register
    dwrite(4'h7, 1, 16'hBEEF);
    dp_sel = 4'h6; dp_word = 1; #1;
    chk("R1 odd-nibble word write", dp_rdata, 16'hBEEF);

    check_window("final window");

    // R6: reset again clears everything
    rst_n = 0; ctx_m = 0;
    for (int a = 0; a < 256; a++) exp_m[a] = 8'h00;
    @(posedge clk); #1 rst_n = 1;
    chk("R6 ctx after second reset", 16'(cur_ctx), 16'h0);
    check_window("R6 zero after second reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule